// File: doc/BRIEF.md
# Flash Self-Programming Command Controller

This block is the control and status register through which a CPU starts flash self-programming. Software writes a command code into the control register. It then executes the program-memory store instruction, which raises `prog_strobe` together with a page/word address and a data word. If the strobe arrives inside a short arming window after the register write, the controller runs the command. A buffer load sends one data word to the page buffer. A page erase or page write sends a request to the flash macro model and waits for its done signal.

During an erase or write the controller sets a sticky region-busy flag. The flag stays set after the operation ends, until software clears it with a re-enable write. The address is split into a page number (upper bits) and a word index (lower `WORD_W` bits). If the page number lies in the stall region, at or above `STALL_FIRST_PAGE`, the CPU is halted for the whole operation. Pages below that bound belong to the concurrent region, and the CPU keeps running while they are programmed. A level interrupt reports that the controller is idle.

The controller is a five-state machine:

| State | Meaning |
|---|---|
| IDLE | Nothing is armed or running. |
| ARMED | A command code was written and the window is open. |
| LOAD | One-cycle buffer load. |
| ISSUE | One-cycle erase or write request. |
| WAIT | Waiting for `flash_done`. |

| Transition | Condition |
|---|---|
| IDLE→ARMED | A valid code is written. |
| ARMED→ARMED | A valid code is written again, which re-arms the controller. |
| ARMED→IDLE | An invalid code is written, or the window expires. |
| ARMED→LOAD | A strobe is accepted for a load. |
| ARMED→ISSUE | A strobe is accepted for an erase or write. |
| LOAD→IDLE | Always. |
| ISSUE→WAIT | Always. |
| WAIT→IDLE | `flash_done` is sampled. |

Top module: `fsp_cmd_ctrl`

## Requirements
- R1: While reset is held and after it is released, every output is 0 and `ctl_rdata` reads 0x00.
- R2: The command codes are as follows. A value whose bits [5:0] are 000011 is an erase, whatever bits 7 and 6 hold. A value whose bits [5:0] are 000101 is a write, whatever bits 7 and 6 hold. Exactly 0x01 is a load, so 0x81 arms nothing. Every register write also stores bit 7 as the interrupt enable.
- R3: An armed command runs only if `prog_strobe` is high in one of the 1st to 4th cycles after the register write cycle. A strobe in the same cycle as the write, or later than the 4th cycle, is ignored, and the arming expires after the 4th cycle.
- R4: A register write of a value that is not a command code cancels any pending arming. A write of a valid code while armed re-arms with the new command and restarts the window.
- R5: An accepted load strobe makes `load_we` high for exactly the next cycle. In that cycle `load_word` carries the strobe's address bits [WORD_W-1:0] and `load_data` carries the strobe's data.
- R6: An accepted erase or write strobe makes `erase_req` or `write_req` high for exactly the next cycle. In that cycle `req_page` carries the address bits above the word field. The word bits and the data have no effect.
- R7: `region_busy` rises in the request cycle of an erase or write. It stays high after completion until a register write with bit 4 set occurs while no load, erase or write is in progress.
- R8: `cpu_halt` is high from the request cycle through the cycle in which `flash_done` is sampled, but only when `req_page >= STALL_FIRST_PAGE`. It is never high for lower pages.
- R9: `ctl_rdata[0]` (command bit) is high from the cycle after a valid code write until the arming is cancelled or expires, the load cycle ends, or `flash_done` is sampled.
- R10: `irq` equals the stored interrupt enable AND NOT the command bit, as a level.
- R11: While a load, erase or write is in progress, register commands, re-enable writes and strobes have no effect. `flash_done` is ignored in the request cycle and whenever no operation is waiting.
- R12: `ctl_rdata` bit layout:

  | Bit | Meaning |
  |---|---|
  | 0 | Command bit |
  | 1 | Erase armed or running |
  | 2 | Write armed or running |
  | 5:3 | Always 0 |
  | 6 | `region_busy` |
  | 7 | Interrupt enable |

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ctl_we | input | 1 | Control register write strobe |
| ctl_wdata | input | 8 | Control register write value |
| ctl_rdata | output | 8 | Control register read value |
| prog_strobe | input | 1 | Program-memory store instruction strobe |
| prog_addr | input | PAGE_W+WORD_W | Page number and word index |
| prog_data | input | DATA_W | Data word for a buffer load |
| flash_done | input | 1 | Erase/write completion from the flash model |
| erase_req | output | 1 | One-cycle page erase request |
| write_req | output | 1 | One-cycle page write request |
| req_page | output | PAGE_W | Page number for the request |
| load_we | output | 1 | One-cycle page buffer write |
| load_word | output | WORD_W | Buffer word index |
| load_data | output | DATA_W | Buffer data |
| region_busy | output | 1 | Sticky busy flag for the concurrent region |
| cpu_halt | output | 1 | CPU halt while the stall region is programmed |
| irq | output | 1 | Level interrupt: enabled and idle |

## Verification
Every output comes from a register, so each result is due in the cycle after the clock edge that samples its cause:
- After a register write, the command bit, the interrupt enable and `irq` change in the next cycle.
- After an accepted strobe, `load_we` or the request pulse appears in the next cycle. `region_busy` and `cpu_halt` rise in that same next cycle.
- After `flash_done` is sampled, `cpu_halt` and the command bit drop in the next cycle.

The bench drives inputs on the falling edge. It advances its behavioural model on the rising edge and compares every output on the following falling edge. Each comparison is therefore made exactly one register stage after its stimulus.

// File: rtl/fsp_pkg.sv
package fsp_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ARMED,
        ST_LOAD,
        ST_ISSUE,
        ST_WAIT
    } fsp_state_e;

    typedef enum logic [1:0] {
        OP_NONE,
        OP_LOAD,
        OP_ERASE,
        OP_WRITE
    } fsp_op_e;

    localparam int BIT_GO    = 0;
    localparam int BIT_ERASE = 1;
    localparam int BIT_WRITE = 2;
    localparam int BIT_REEN  = 4;
    localparam int BIT_BUSY  = 6;
    localparam int BIT_IE    = 7;

    localparam logic [5:0] CODE_ERASE = 6'b000011;
    localparam logic [5:0] CODE_WRITE = 6'b000101;
    localparam logic [7:0] CODE_LOAD  = 8'h01;

    function automatic fsp_op_e decode_ctl(input logic [7:0] v);
        fsp_op_e r;
        if (v == CODE_LOAD)
            r = OP_LOAD;
        else if (v[5:0] == CODE_ERASE)
            r = OP_ERASE;
        else if (v[5:0] == CODE_WRITE)
            r = OP_WRITE;
        else
            r = OP_NONE;
        return r;
    endfunction

endpackage

// File: rtl/fsp_decode.sv
module fsp_decode
    import fsp_pkg::*;
(
    input  logic [7:0] wdata,
    output fsp_op_e    op,
    output logic       valid,
    output logic       reen,
    output logic       ie
);
    always_comb begin
        op    = decode_ctl(wdata);
        valid = (op != OP_NONE);
        reen  = wdata[BIT_REEN];
        ie    = wdata[BIT_IE];
    end
endmodule

// File: rtl/fsp_arm_timer.sv
module fsp_arm_timer #(
    parameter int WINDOW = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic last
);
    localparam int CW = (WINDOW > 1) ? $clog2(WINDOW) : 1;
    localparam logic [CW-1:0] LAST_V = CW'(WINDOW - 1);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt <= '0;
        else if (start)
            cnt <= '0;
        else if (cnt != LAST_V)
            cnt <= cnt + 1'b1;
    end

    assign last = (cnt == LAST_V);

    // R3
    window_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> (!last || (WINDOW == 1)));
endmodule

// File: rtl/fsp_region.sv
module fsp_region #(
    parameter int PAGE_W           = 6,
    parameter int STALL_FIRST_PAGE = 48
) (
    input  logic [PAGE_W-1:0] page,
    output logic              stall
);
    generate
        if (STALL_FIRST_PAGE <= 0) begin : g_all
            assign stall = 1'b1;
        end else if (STALL_FIRST_PAGE >= (1 << PAGE_W)) begin : g_none
            assign stall = 1'b0;
        end else begin : g_cmp
            assign stall = (page >= PAGE_W'(STALL_FIRST_PAGE));
        end
    endgenerate
endmodule

// File: rtl/fsp_status.sv
module fsp_status (
    input  logic clk,
    input  logic rst_n,
    input  logic wr,
    input  logic ie_in,
    input  logic busy_set,
    input  logic busy_clr,
    input  logic go,
    output logic busy,
    output logic ie,
    output logic irq
);
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            ie   <= 1'b0;
        end else begin
            if (wr)
                ie <= ie_in;
            if (busy_set)
                busy <= 1'b1;
            else if (busy_clr)
                busy <= 1'b0;
        end
    end

    always_comb irq = ie && !go;

    // R7
    busy_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !busy_clr) |=> busy);
endmodule

// File: rtl/fsp_cmd_ctrl.sv
module fsp_cmd_ctrl
    import fsp_pkg::*;
#(
    parameter int PAGE_W           = 6,
    parameter int WORD_W           = 4,
    parameter int DATA_W           = 16,
    parameter int WINDOW           = 4,
    parameter int STALL_FIRST_PAGE = 48
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     ctl_we,
    input  logic [7:0]               ctl_wdata,
    output logic [7:0]               ctl_rdata,
    input  logic                     prog_strobe,
    input  logic [PAGE_W+WORD_W-1:0] prog_addr,
    input  logic [DATA_W-1:0]        prog_data,
    input  logic                     flash_done,
    output logic                     erase_req,
    output logic                     write_req,
    output logic [PAGE_W-1:0]        req_page,
    output logic                     load_we,
    output logic [WORD_W-1:0]        load_word,
    output logic [DATA_W-1:0]        load_data,
    output logic                     region_busy,
    output logic                     cpu_halt,
    output logic                     irq
);
    localparam int ADDR_W = PAGE_W + WORD_W;

    fsp_state_e state, state_nx;
    fsp_op_e    op_q, dec_op;
    logic       dec_valid, dec_reen, dec_ie;
    logic       win_last, arm_start, accept, quiet, go;
    logic       busy_set, busy_clr, ie_q, stall_in, stall_q;
    logic [PAGE_W-1:0] page_q;
    logic [WORD_W-1:0] word_q;
    logic [DATA_W-1:0] data_q;

    fsp_decode u_dec (
        .wdata (ctl_wdata),
        .op    (dec_op),
        .valid (dec_valid),
        .reen  (dec_reen),
        .ie    (dec_ie)
    );

    fsp_arm_timer #(.WINDOW(WINDOW)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .start (arm_start),
        .last  (win_last)
    );

    fsp_region #(.PAGE_W(PAGE_W), .STALL_FIRST_PAGE(STALL_FIRST_PAGE)) u_reg (
        .page  (prog_addr[ADDR_W-1:WORD_W]),
        .stall (stall_in)
    );

    // Idle or armed: the only states that take register commands.
    always_comb quiet     = (state == ST_IDLE) || (state == ST_ARMED);
    always_comb arm_start = quiet && ctl_we && dec_valid;
    always_comb accept    = (state == ST_ARMED) && !ctl_we && prog_strobe;
    always_comb go        = (state != ST_IDLE);
    always_comb busy_set  = accept && ((op_q == OP_ERASE) || (op_q == OP_WRITE));
    always_comb busy_clr  = quiet && ctl_we && dec_reen;

    fsp_status u_sts (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr       (ctl_we),
        .ie_in    (dec_ie),
        .busy_set (busy_set),
        .busy_clr (busy_clr),
        .go       (go),
        .busy     (region_busy),
        .ie       (ie_q),
        .irq      (irq)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ST_IDLE;
        else
            state <= state_nx;
    end

    // Next-state logic
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: begin
                if (ctl_we && dec_valid)
                    state_nx = ST_ARMED;
            end
            ST_ARMED: begin
                if (ctl_we)
                    state_nx = dec_valid ? ST_ARMED : ST_IDLE;
                else if (prog_strobe)
                    state_nx = (op_q == OP_LOAD) ? ST_LOAD : ST_ISSUE;
                else if (win_last)
                    state_nx = ST_IDLE;
            end
            ST_LOAD:  state_nx = ST_IDLE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT: begin
                if (flash_done)
                    state_nx = ST_IDLE;
            end
            default:  state_nx = ST_IDLE;
        endcase
    end

    // Command and operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q    <= OP_NONE;
            page_q  <= '0;
            word_q  <= '0;
            data_q  <= '0;
            stall_q <= 1'b0;
        end else begin
            if (arm_start)
                op_q <= dec_op;
            if (accept) begin
                page_q  <= prog_addr[ADDR_W-1:WORD_W];
                word_q  <= prog_addr[WORD_W-1:0];
                data_q  <= prog_data;
                stall_q <= stall_in;
            end
        end
    end

    // Outputs
    always_comb begin
        erase_req = 1'b0;
        write_req = 1'b0;
        load_we   = 1'b0;
        cpu_halt  = 1'b0;
        unique case (state)
            ST_IDLE, ST_ARMED: ;
            ST_LOAD:  load_we = 1'b1;
            ST_ISSUE: begin
                erase_req = (op_q == OP_ERASE);
                write_req = (op_q == OP_WRITE);
                cpu_halt  = stall_q;
            end
            ST_WAIT:  cpu_halt = stall_q;
            default: ;
        endcase
        req_page  = page_q;
        load_word = word_q;
        load_data = data_q;
        ctl_rdata = '0;
        ctl_rdata[BIT_GO]    = go;
        ctl_rdata[BIT_ERASE] = go && (op_q == OP_ERASE);
        ctl_rdata[BIT_WRITE] = go && (op_q == OP_WRITE);
        ctl_rdata[BIT_BUSY]  = region_busy;
        ctl_rdata[BIT_IE]    = ie_q;
    end

    // R5
    load_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |-> $past(prog_strobe && !ctl_we));
    // R5
    load_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        load_we |=> !load_we);
    // R6
    req_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (erase_req || write_req) |-> $past(prog_strobe && !ctl_we));
    // R7
    busy_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(region_busy) |-> $past(ctl_we && ctl_wdata[BIT_REEN]));
    // R8
    halt_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_halt |-> region_busy);
    // R11
    req_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({erase_req, write_req, load_we}) <= 1);
endmodule

// File: tb/tb_fsp_cmd_ctrl.sv
`timescale 1ns/1ps
module tb_fsp_cmd_ctrl;
    localparam int PAGE_W = 6;
    localparam int WORD_W = 4;
    localparam int DATA_W = 16;
    localparam int STALL  = 48;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ctl_we = 1'b0;
    logic [7:0] ctl_wdata = '0;
    logic prog_strobe = 1'b0;
    logic [PAGE_W+WORD_W-1:0] prog_addr = '0;
    logic [DATA_W-1:0] prog_data = '0;
    logic flash_done = 1'b0;
    logic [7:0] ctl_rdata;
    logic erase_req, write_req, load_we, region_busy, cpu_halt, irq;
    logic [PAGE_W-1:0] req_page;
    logic [WORD_W-1:0] load_word;
    logic [DATA_W-1:0] load_data;

    int n_chk = 0;
    int n_fail = 0;
    string scn = "R1 reset";

    always #2.5 clk = ~clk;

    fsp_cmd_ctrl #(.PAGE_W(PAGE_W), .WORD_W(WORD_W), .DATA_W(DATA_W),
                   .WINDOW(4), .STALL_FIRST_PAGE(STALL)) dut (
        .clk(clk), .rst_n(rst_n), .ctl_we(ctl_we), .ctl_wdata(ctl_wdata),
        .ctl_rdata(ctl_rdata), .prog_strobe(prog_strobe), .prog_addr(prog_addr),
        .prog_data(prog_data), .flash_done(flash_done), .erase_req(erase_req),
        .write_req(write_req), .req_page(req_page), .load_we(load_we),
        .load_word(load_word), .load_data(load_data), .region_busy(region_busy),
        .cpu_halt(cpu_halt), .irq(irq)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s [%s] %s: actual %0h expected %0h", req, scn, what, act, exp);
        end
    endtask

    // Behavioural reference model
    int m_age = -1;   // cycles since arming, -1 when nothing is armed
    int m_kind = 0;   // 1 load, 2 erase, 3 write
    bit m_loadp = 0, m_reqp = 0, m_op = 0, m_busy = 0, m_ie = 0, m_stall = 0;
    int m_page = 0, m_word = 0, m_data = 0;

    function automatic int kind_of(input logic [7:0] v);
        if (v == 8'h01) return 1;
        if (v[5:0] == 6'b000011) return 2;
        if (v[5:0] == 6'b000101) return 3;
        return 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_age = -1; m_kind = 0; m_loadp = 0; m_reqp = 0; m_op = 0;
            m_busy = 0; m_ie = 0; m_stall = 0;
        end else begin
            if (ctl_we) m_ie = ctl_wdata[7];
            if (m_loadp) begin
                m_loadp = 0;
            end else if (m_op) begin
                if (m_reqp) m_reqp = 0;
                else if (flash_done) m_op = 0;
            end else if (ctl_we) begin
                if (kind_of(ctl_wdata) != 0) begin
                    m_age = 0; m_kind = kind_of(ctl_wdata);
                end else begin
                    m_age = -1;
                end
                if (ctl_wdata[4]) m_busy = 0;
            end else if (m_age >= 0) begin
                if (prog_strobe) begin
                    m_age = -1;
                    if (m_kind == 1) begin
                        m_loadp = 1;
                        m_word = int'(prog_addr) % (1 << WORD_W);
                        m_data = int'(prog_data);
                    end else begin
                        m_op = 1; m_reqp = 1; m_busy = 1;
                        m_page = int'(prog_addr) >> WORD_W;
                        m_stall = (m_page >= STALL);
                    end
                end else begin
                    m_age++;
                    if (m_age >= 4) m_age = -1;
                end
            end
        end
    end

    // Compare every cycle, on the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            automatic bit go = (m_age >= 0) || m_loadp || m_op;
            automatic int exp_rd = (m_ie << 7) | (m_busy << 6)
                | ((go && m_kind == 3) << 2) | ((go && m_kind == 2) << 1) | int'(go);
            chk("R12", "ctl_rdata", int'(ctl_rdata), exp_rd);
            chk("R9", "command bit", int'(ctl_rdata[0]), int'(go));
            chk("R10", "irq", int'(irq), int'(m_ie && !go));
            chk("R8", "cpu_halt", int'(cpu_halt), int'(m_op && m_stall));
            chk("R7", "region_busy", int'(region_busy), int'(m_busy));
            chk("R6", "erase_req", int'(erase_req), int'(m_reqp && m_kind == 2));
            chk("R6", "write_req", int'(write_req), int'(m_reqp && m_kind == 3));
            if (m_reqp) chk("R6", "req_page", int'(req_page), m_page);
            chk("R5", "load_we", int'(load_we), int'(m_loadp));
            if (m_loadp) begin
                chk("R5", "load_word", int'(load_word), m_word);
                chk("R5", "load_data", int'(load_data), m_data);
            end
        end
    end

    task automatic gap(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] v);
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk); ctl_we = 1'b0;
    endtask

    // strobe in the k-th cycle after the register write cycle
    task automatic strobe_at(input int k, input int page, input int word, input int data);
        if (k > 1) repeat (k - 1) @(negedge clk);
        prog_strobe = 1'b1;
        prog_addr = (PAGE_W+WORD_W)'((page << WORD_W) | word);
        prog_data = DATA_W'(data);
        @(negedge clk); prog_strobe = 1'b0;
    endtask

    task automatic done_now();
        flash_done = 1'b1;
        @(negedge clk); flash_done = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        n_fail++; n_chk++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        scn = "R1 reset";
        gap(3);
        chk("R1", "rdata in reset", int'(ctl_rdata), 0);
        chk("R1", "outputs in reset", int'({erase_req, write_req, load_we, region_busy, cpu_halt, irq}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1", "rdata after reset", int'(ctl_rdata), 0);

        scn = "R5 load k=1";
        wr(8'h01); strobe_at(1, 5, 9, 16'hBEEF); gap(3);

        scn = "R3 load k=4 accepted";
        wr(8'h01); strobe_at(4, 7, 2, 16'h5A5A); gap(3);

        scn = "R3 load k=5 rejected";
        wr(8'h01); strobe_at(5, 7, 3, 16'h1111); gap(3);

        scn = "R3 strobe with write ignored";
        @(negedge clk); ctl_we = 1'b1; ctl_wdata = 8'h01; prog_strobe = 1'b1;
        @(negedge clk); ctl_we = 1'b0; prog_strobe = 1'b0; gap(6);

        scn = "R2 0x81 arms nothing";
        wr(8'h81); strobe_at(1, 1, 1, 16'h2222); gap(2);
        wr(8'h00); gap(2);

        scn = "R6 erase concurrent region, data ignored";
        wr(8'h83); strobe_at(2, 3, 7, 16'h1234); gap(3);
        done_now(); gap(4);
        scn = "R7 busy sticky then cleared";
        wr(8'h90); gap(3);

        scn = "R8 write stall region";
        wr(8'h05); strobe_at(3, 50, 0, 16'h0);
        scn = "R11 done in request cycle ignored";
        done_now();
        scn = "R11 commands during op ignored";
        wr(8'h03); strobe_at(1, 2, 0, 0); wr(8'h10); gap(3);
        scn = "R8 write completes";
        done_now(); gap(3);
        scn = "R7 clear after write";
        wr(8'h10); gap(2);

        scn = "R4 invalid write cancels";
        wr(8'h03); wr(8'h20); strobe_at(1, 4, 0, 0); gap(3);

        scn = "R4 rearm with load";
        wr(8'h03); gap(2); wr(8'h01); strobe_at(1, 6, 14, 16'hCAFE); gap(3);

        scn = "R2 erase with bit6 set";
        wr(8'h43); strobe_at(1, 10, 0, 0); gap(2); done_now(); gap(2);

        scn = "R8 erase last page halts";
        wr(8'h03); strobe_at(4, 63, 0, 0); gap(5); done_now(); gap(2);

        scn = "R11 stray done ignored";
        done_now(); gap(2);
        wr(8'h10); gap(2);

        scn = "R3 arming expires";
        wr(8'h05); gap(6); strobe_at(1, 20, 0, 0); gap(3);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule